// File: doc/BRIEF.md
# Send-Level Gated Pixel Queue with Channel Filter

This block sits between a camera-link packet receiver and a video output port. Each incoming pixel word carries a 2-bit channel tag and a line-end marker. A programmable filter either lets every word through or keeps only the words whose tag matches a programmed channel number. Kept words enter a first-in first-out queue. The output side sees nothing until the queue holds at least a programmed number of words, the send level. Once released, the queue streams until the word that carries the line-end marker has left it. The block then closes the gate again, so each new line must again build up to the send level before it is sent.

The send level balances rate mismatch. If the output is 10% faster than the input on a 500-pixel line, a level of about 50 keeps the output free of gaps. The reset value is 64. A level of 16 is enough when gaps in the output can be tolerated.

The input side has no back-pressure: `in_valid` words are never stalled. If an accepted word meets a full queue, the word is lost and a sticky overflow flag is set. The output uses valid/ready. A word moves only in a cycle where both `out_valid` and `out_ready` are high. While `out_valid` is high and `out_ready` is low, `out_data` and `out_eol` hold their values. Settings are written through a plain write port, and the write takes effect at the next clock edge.

Top module: `pxq_gate_top`

## Requirements
- R1: After reset, `out_valid` and `ovf_flag` are 0. The reset settings are: filter bypass 1 (accept every tag), channel match 0, send level 64.
- R2: While the bypass setting is 1, each `in_valid` word is queued whatever its `in_vc` value.
- R3: While the bypass setting is 0, only words with `in_vc` equal to the channel-match setting are queued. All other words are discarded and never appear at the output.
- R4: While the gate is closed, `out_valid` is 0. The gate opens at the clock edge where the queue holds at least the send-level number of words, so `out_valid` rises one cycle after the count reaches the level.
- R5: A completely full queue (DEPTH words) also opens the gate, even when the send level is larger than DEPTH.
- R6: While the gate is open, `out_valid` is high whenever the queue is not empty. Transferring a word with `out_eol`=1 closes the gate from the next cycle.
- R7: Words leave in arrival order, with `out_data` and `out_eol` equal to the `in_data` and `in_eol` that were queued.
- R8: A word is removed only when `out_valid` and `out_ready` are both high. While the output is stalled, `out_data` and `out_eol` stay stable.
- R9: An accepted word that arrives while the queue holds DEPTH words is dropped, and `ovf_flag` goes to 1. It stays 1 until it is cleared.
- R10: A write to address 3 clears `ovf_flag`. If a drop happens in the same cycle, the flag stays 1.
- R11: The write addresses and fields are:
  - address 0, bit 0: filter bypass
  - address 1, bits 1:0: channel match
  - address 2, bits CFG_W-1:0: send level
  - address 3: overflow clear (data ignored)

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present this cycle |
| in_vc | input | 2 | Channel tag of the input word |
| in_data | input | DW | Input pixel word |
| in_eol | input | 1 | Input word ends a line |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | 2 | Setting address |
| cfg_wdata | input | CFG_W | Setting write data |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | DW | Output pixel word |
| out_eol | output | 1 | Output word ends a line |
| ovf_flag | output | 1 | Sticky overflow indication |

## Verification
The hardest situation to reach from the ports is a full queue whose send level is larger than its depth. In that state, release must come from the full condition alone while further accepted words are being dropped. A clear write landing in the same cycle as a drop is harder still. The stimulus sets the level above DEPTH and holds `out_ready` low. It then pushes more words than the queue can hold, and issues one clear write on its own and a second one together with a drop. The remaining stimulus is random: short send levels, random ready, random tags and filter settings, and random line ends. All of it is compared every cycle against a word-level queue model.

// File: rtl/pxq_pkg.sv
package pxq_pkg;
  localparam int VC_W = 2;
  localparam int RESET_SEND_LVL = 64;

  typedef enum logic [1:0] {
    A_VC_BYPASS = 2'd0,
    A_VC_MATCH  = 2'd1,
    A_SEND_LVL  = 2'd2,
    A_OVF_CLR   = 2'd3
  } cfg_addr_e;
endpackage

// File: rtl/pxq_cfg_filter.sv
module pxq_cfg_filter
  import pxq_pkg::*;
#(
  parameter int CFG_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_addr,
  input  logic [CFG_W-1:0]    cfg_wdata,
  input  logic                in_valid,
  input  logic [VC_W-1:0]     in_vc,
  output logic                accept,
  output logic                vc_bypass,
  output logic [VC_W-1:0]     vc_match,
  output logic [CFG_W-1:0]    send_lvl,
  output logic                ovf_clr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vc_bypass <= 1'b1;
      vc_match  <= '0;
      send_lvl  <= CFG_W'(RESET_SEND_LVL);
    end else if (cfg_we) begin
      case (cfg_addr)
        A_VC_BYPASS: vc_bypass <= cfg_wdata[0];
        A_VC_MATCH:  vc_match  <= cfg_wdata[VC_W-1:0];
        A_SEND_LVL:  send_lvl  <= cfg_wdata;
        default: ;
      endcase
    end
  end

  assign ovf_clr = cfg_we && (cfg_addr == A_OVF_CLR);
  assign accept  = in_valid && (vc_bypass || (in_vc == vc_match));
endmodule

// File: rtl/pxq_fifo.sv
module pxq_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 128,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW:0]   wdata,
  input  logic          pop,
  output logic [DW:0]   rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW:0]   mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  assign rdata = mem[rd_ptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/pxq_release_ctl.sv
module pxq_release_ctl #(
  parameter int DEPTH = 128,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    count,
  input  logic [CFG_W-1:0] send_lvl,
  input  logic             pop,
  input  logic             head_eol,
  input  logic             drop,
  input  logic             ovf_clr,
  output logic             run,
  output logic             ovf
);
  logic lvl_hit, at_cap;

  assign lvl_hit = (32'(count) >= 32'(send_lvl));
  assign at_cap  = (32'(count) == 32'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
    end else if (!run && (lvl_hit || at_cap)) begin
      run <= 1'b1;
    end else if (run && pop && head_eol) begin
      run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ovf <= 1'b0;
    else if (drop)    ovf <= 1'b1;
    else if (ovf_clr) ovf <= 1'b0;
  end
endmodule

// File: rtl/pxq_gate_top.sv
module pxq_gate_top
  import pxq_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 128,
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_vc,
  input  logic [DW-1:0]    in_data,
  input  logic             in_eol,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic             out_eol,
  output logic             ovf_flag
);
  localparam int CW = $clog2(DEPTH + 1);

  logic             accept, vc_bypass, ovf_clr;
  logic [VC_W-1:0]  vc_match;
  logic [CFG_W-1:0] send_lvl;
  logic             push, pop, drop, run;
  logic [DW:0]      head;
  logic [CW-1:0]    fifo_cnt;
  logic             fifo_full, fifo_empty;

  pxq_cfg_filter #(.CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_vc(in_vc),
    .accept(accept), .vc_bypass(vc_bypass), .vc_match(vc_match),
    .send_lvl(send_lvl), .ovf_clr(ovf_clr)
  );

  assign push = accept && !fifo_full;
  assign drop = accept && fifo_full;
  assign pop  = out_valid && out_ready;

  pxq_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push), .wdata({in_eol, in_data}),
    .pop(pop), .rdata(head),
    .count(fifo_cnt), .full(fifo_full), .empty(fifo_empty)
  );

  pxq_release_ctl #(.DEPTH(DEPTH), .CW(CW), .CFG_W(CFG_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .count(fifo_cnt), .send_lvl(send_lvl),
    .pop(pop), .head_eol(head[DW]),
    .drop(drop), .ovf_clr(ovf_clr),
    .run(run), .ovf(ovf_flag)
  );

  assign out_valid = run && !fifo_empty;
  assign out_data  = head[DW-1:0];
  assign out_eol   = head[DW];
endmodule

// File: rtl/pxq_gate_chk.sv
module pxq_gate_chk #(
  parameter int DW    = 16,
  parameter int DEPTH = 128,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [1:0]    in_vc,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_eol,
  input logic          ovf_flag,
  input logic          cfg_we,
  input logic [1:0]    cfg_addr,
  input logic [CW-1:0] fifo_cnt,
  input logic          vc_bypass,
  input logic [1:0]    vc_match
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_eol));

  p_eol_regate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_eol |=> !out_valid);

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fifo_cnt) <= 32'(DEPTH));

  p_drop_sets_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(fifo_cnt) == 32'(DEPTH)) && in_valid && (vc_bypass || in_vc == vc_match)
      |=> ovf_flag);

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !(cfg_we && cfg_addr == 2'd3) |=> ovf_flag);
endmodule

bind pxq_gate_top pxq_gate_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_eol(out_eol), .ovf_flag(ovf_flag), .cfg_we(cfg_we),
  .cfg_addr(cfg_addr), .fifo_cnt(fifo_cnt), .vc_bypass(vc_bypass),
  .vc_match(vc_match)
);

// File: tb/test_pxq_gate_top.sv
module test_pxq_gate_top;
  localparam int DW = 16, DEPTH = 128, CFG_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_eol = 1'b0, cfg_we = 1'b0, out_ready = 1'b0;
  logic [1:0] in_vc = '0, cfg_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic out_valid, out_eol, ovf_flag;
  logic [DW-1:0] out_data;

  always #10 clk = ~clk;

  pxq_gate_top #(.DW(DW), .DEPTH(DEPTH), .CFG_W(CFG_W)) i_pxq_gate_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc),
    .in_data(in_data), .in_eol(in_eol), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_eol(out_eol), .ovf_flag(ovf_flag)
  );

  int nvec = 0, nbad = 0;
  bit done = 0;
  string ph = "R1 reset";

  logic [DW:0] q[$];
  bit m_run = 0, m_ovf = 0, m_byp = 1;
  logic [1:0] m_vc = 2'd0;
  int m_lvl = 64;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic bit m_valid();
    return m_run && (q.size() > 0);
  endfunction

  task automatic model_step();
    bit acc, full, pop, heol, nrun;
    int cnt;
    cnt  = q.size();
    full = (cnt == DEPTH);
    acc  = in_valid && (m_byp || in_vc == m_vc);
    pop  = m_run && cnt > 0 && out_ready;
    heol = pop ? q[0][DW] : 1'b0;
    nrun = m_run;
    if (!m_run && (cnt >= m_lvl || full)) nrun = 1;
    else if (m_run && pop && heol) nrun = 0;
    if (pop) void'(q.pop_front());
    if (acc && !full) q.push_back({in_eol, in_data});
    if (cfg_we && cfg_addr == 2'd3) m_ovf = 0;
    if (acc && full) m_ovf = 1;
    if (cfg_we) begin
      if (cfg_addr == 2'd0) m_byp = cfg_wdata[0];
      if (cfg_addr == 2'd1) m_vc = cfg_wdata[1:0];
      if (cfg_addr == 2'd2) m_lvl = int'(cfg_wdata);
    end
    m_run = nrun;
  endtask

  task automatic compare();
    chk({ph, " out_valid gate (R4 R6)"}, 32'(out_valid), 32'(m_valid()));
    if (m_valid() && out_valid) begin
      chk({ph, " out_data order (R7)"}, 32'(out_data), 32'(q[0][DW-1:0]));
      chk({ph, " out_eol (R7)"}, 32'(out_eol), 32'(q[0][DW]));
    end
    chk({ph, " ovf_flag (R9)"}, 32'(ovf_flag), 32'(m_ovf));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    cfg_we = 1'b0;
    in_valid = 1'b0;
  endtask

  task automatic drv(bit v, logic [1:0] vc, bit eol, bit rdy);
    in_valid = v; in_vc = vc; in_eol = eol; out_ready = rdy;
    in_data = DW'($urandom);
    tick();
  endtask

  task automatic wr(logic [1:0] a, int d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = CFG_W'(d);
    tick();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL R6 watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset out_valid", 32'(out_valid), 32'd0);
    chk("R1 reset ovf_flag", 32'(ovf_flag), 32'd0);
    compare();

    // R1 R2 R4: default level 64, default bypass accepts every tag
    ph = "R1 R2 R4 default level";
    for (int i = 0; i < 63; i++) drv(1, 2'(i), 0, 1);
    chk("R4 no release below level", 32'(out_valid), 32'd0);
    drv(1, 2'd3, 1, 1);
    drv(0, 0, 0, 1);
    chk("R4 release at level", 32'(out_valid), 32'd1);
    while (q.size() > 0) drv(0, 0, 0, 1);
    chk("R6 gate closed after eol", 32'(out_valid), 32'd0);

    // R11 R3: filter on channel 2, level 4
    ph = "R3 R11 channel filter";
    wr(2'd0, 0);
    wr(2'd1, 2);
    wr(2'd2, 4);
    for (int i = 0; i < 40; i++) drv(1, 2'($urandom), (i % 9) == 8, 1);
    for (int i = 0; i < 20; i++) drv(0, 0, 0, 1);

    // R5 R9 R10: level above depth, stalled output, overflow
    ph = "R5 R9 R10 full queue";
    wr(2'd0, 1);
    wr(2'd2, 200);
    for (int i = 0; i < DEPTH + 12; i++) drv(1, 2'($urandom), 0, 0);
    chk("R5 release on full", 32'(out_valid), 32'd1);
    chk("R9 overflow sticky", 32'(ovf_flag), 32'd1);
    wr(2'd3, 0);
    chk("R10 clear ovf", 32'(ovf_flag), 32'd0);
    in_valid = 1'b1; in_vc = 2'd1; out_ready = 1'b0;
    cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = '0;
    tick();
    chk("R10 drop wins over clear", 32'(ovf_flag), 32'd1);
    wr(2'd3, 0);
    ph = "R8 drain";
    while (q.size() > 0) drv(0, 0, 0, 1);

    // R8 R6 R7: random traffic with back-pressure
    ph = "R2 R3 R6 R7 R8 random";
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 50) == 0) wr(2'd2, int'($urandom % 25));
      else if (($urandom % 120) == 0) wr(2'd0, int'($urandom % 2));
      else if (($urandom % 120) == 0) wr(2'd1, int'($urandom % 4));
      else drv(($urandom % 3) != 0, 2'($urandom), ($urandom % 7) == 0,
               ($urandom % 4) != 0);
    end
    done = 1;
    summary();
    $finish;
  end
endmodule